// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Refill

This block turns virtual addresses from a processor into physical addresses. It keeps a small, fully associative cache of recent translations. When a lookup misses, it reads one page-table entry from memory, at an address taken from a base register plus the scaled page number. It then checks the entry's present bit and permission field against the kind of access requested. The result is either a physical address or a fault code.

Requests are accepted one at a time. A hit answers in the next cycle. A miss holds off further requests until its entry has been fetched and the response has been produced. Writing the base register selects a new table, as on a process switch, and drops every cached translation.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_req` are 0, and the translation cache is empty, so the first access to any page misses.
- R2: A virtual address is split into page number `[31:12]` and offset `[11:0]`. A successful translation returns `{ppn, offset}`, with the offset copied unchanged.
- R3: On a miss the block raises `mem_rd_req` for exactly one cycle, with `mem_rd_addr = base + page_number*4`. It answers with `rsp_hit`=0 in the cycle after the one in which `mem_rsp_valid` is sampled high.
- R4: On a hit the block answers in the cycle after acceptance, with `rsp_hit`=1 and no memory read.
- R5: A table entry is laid out as `[31]` present, `[30:29]` rights, `[19:0]` physical page number. If the present bit is 0, the response carries fault code 01 (absent) and paddr 0. Such an entry is not cached, so a repeat request misses again.
- R6: Rights codes are 00 read-only, 01 read/write, 10 execute-only and 11 no access. Access kinds are 00 read, 01 write and 10 execute; kind 11 is never permitted. Reads are permitted by codes 00 and 01, writes by code 01, and executes by code 10. A present entry that does not permit the requested kind gives fault code 10 (protection) with paddr 0, on a hit and on a miss alike. Such entries are still cached.
- R7: The cache has 16 entries. When it is full, a refill replaces the least recently used entry, where both hits and fills count as use.
- R8: Writing the base register invalidates every cached translation. Later refills use the new base.
- R9: `req_ready` is 0 from acceptance of a missing request until its response. Each accepted request gets exactly one response. A successful response carries fault code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| base_wr | input | 1 | Load base register; flushes the cache |
| base_wdata | input | 32 | New page-table base address |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | Response served from the cache |
| rsp_fault | output | 2 | 00 none, 01 absent, 10 protection |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_rd_req | output | 1 | One-cycle read request for a table entry |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The assertions take three things for granted about the inputs. First, `base_wr` is asserted only while the block is idle and no request is being offered. Second, `mem_rsp_valid` pulses once for each read request. Third, the table never maps two virtual pages that are both cached in a way that breaks uniqueness of page numbers. The third holds automatically, because the cache is keyed by virtual page. The stimulus writes the base register only between completed transactions. Its memory model returns exactly one word, one cycle after each request, and derives every entry from its page number and the current base. That way every table word, and every expected address, is known in advance.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = 20;
    localparam int PTE_W   = 32;
    localparam int PTE_PRESENT = 31;
    localparam int PTE_RT_HI   = 30;
    localparam int PTE_RT_LO   = 29;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_BAD   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RT_RO   = 2'b00,
        RT_RW   = 2'b01,
        RT_EX   = 2'b10,
        RT_NONE = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        rights_e          rights;
        logic [PPN_W-1:0] ppn;
    } xent_t;

    function automatic logic kind_allowed(rights_e r, acc_e k);
        case (k)
            ACC_READ:  return (r == RT_RO) || (r == RT_RW);
            ACC_WRITE: return (r == RT_RW);
            ACC_EXEC:  return (r == RT_EX);
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru
    import xlat_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 touch,
    input  logic [$clog2(N)-1:0] touch_idx,
    output logic [$clog2(N)-1:0] oldest_idx
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] MAX_AGE = IW'(N - 1);

    logic [IW-1:0] age_q [N];
    logic [N-1:0]  oldest_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (age_q[i] == MAX_AGE);
            if (oldest_vec[i]) oldest_idx = IW'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1); // R7
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_use,
    output logic             lk_hit,
    output xent_t            lk_ent,
    input  logic             fill_en,
    input  xent_t            fill_ent,
    input  logic             flush
);
    localparam int IW = $clog2(N);

    xent_t         ent_q [N];
    logic [N-1:0]  vld_q;
    logic [N-1:0]  match_vec;
    logic [N-1:0]  fill_match;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] free_idx;
    logic          have_free;
    logic [IW-1:0] lru_idx;
    logic [IW-1:0] victim_idx;
    logic          touch;
    logic [IW-1:0] touch_idx;

    always_comb begin
        hit_idx   = '0;
        free_idx  = '0;
        have_free = 1'b0;
        lk_ent    = '0;
        for (int i = 0; i < N; i++) begin
            match_vec[i]  = vld_q[i] && (ent_q[i].vpn == lk_vpn);
            fill_match[i] = vld_q[i] && (ent_q[i].vpn == fill_ent.vpn);
            if (match_vec[i]) begin
                hit_idx = IW'(i);
                lk_ent  = ent_q[i];
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx  = IW'(i);
                have_free = 1'b1;
            end
        end
    end

    assign lk_hit     = |match_vec;
    assign victim_idx = have_free ? free_idx : lru_idx;
    assign touch      = fill_en || (lk_use && lk_hit);
    assign touch_idx  = fill_en ? victim_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[victim_idx] <= 1'b1;
            ent_q[victim_idx] <= fill_ent;
        end
    end

    xlat_lru #(.N(N)) u_lru (
        .clk        (clk),
        .rst        (rst || flush),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .oldest_idx (lru_idx)
    );

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec)); // R4
    AST_FILL_FRESH: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !(|fill_match)); // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_en) |=> !lk_hit); // R8
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic [VA_W-1:0]  base,
    input  logic             lk_hit,
    input  xent_t            lk_ent,
    output logic             lk_use,
    output logic             fill_en,
    output xent_t            fill_ent,
    output logic             mem_rd_req,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [1:0]       rsp_fault,
    output logic [VA_W-1:0]  rsp_paddr
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} wstate_e;

    wstate_e          st_q;
    logic [VPN_W-1:0] pend_vpn;
    logic [OFF_W-1:0] pend_off;
    acc_e             pend_kind;
    logic [VA_W-1:0]  rd_addr_q;
    logic             pte_present;
    rights_e          pte_rights;
    logic [PPN_W-1:0] pte_ppn;
    logic             unused_pte;

    assign req_ready  = (st_q == ST_IDLE);
    assign lk_use     = req_valid && req_ready;
    assign mem_rd_req = (st_q == ST_ISSUE);
    assign mem_rd_addr = rd_addr_q;

    assign pte_present = mem_rsp_data[PTE_PRESENT];
    assign pte_rights  = rights_e'(mem_rsp_data[PTE_RT_HI:PTE_RT_LO]);
    assign pte_ppn     = mem_rsp_data[PPN_W-1:0];
    assign unused_pte  = ^mem_rsp_data[PTE_RT_LO-1:PPN_W];

    assign fill_en  = (st_q == ST_WAIT) && mem_rsp_valid && pte_present;
    assign fill_ent = '{vpn: pend_vpn, rights: pte_rights, ppn: pte_ppn};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= '0;
            pend_vpn  <= '0;
            pend_off  <= '0;
            pend_kind <= ACC_READ;
            rd_addr_q <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: if (lk_use) begin
                    if (lk_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        if (kind_allowed(lk_ent.rights, acc_e'(req_kind))) begin
                            rsp_fault <= FLT_NONE;
                            rsp_paddr <= {lk_ent.ppn, req_vaddr[OFF_W-1:0]};
                        end else begin
                            rsp_fault <= FLT_PROT;
                            rsp_paddr <= '0;
                        end
                    end else begin
                        pend_vpn  <= req_vaddr[VA_W-1:OFF_W];
                        pend_off  <= req_vaddr[OFF_W-1:0];
                        pend_kind <= acc_e'(req_kind);
                        rd_addr_q <= base + {{(VA_W-VPN_W-2){1'b0}},
                                             req_vaddr[VA_W-1:OFF_W], 2'b00};
                        st_q      <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    st_q      <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_paddr <= '0;
                    if (!pte_present)
                        rsp_fault <= FLT_ABSENT;
                    else if (!kind_allowed(pte_rights, pend_kind))
                        rsp_fault <= FLT_PROT;
                    else begin
                        rsp_fault <= FLT_NONE;
                        rsp_paddr <= {pte_ppn, pend_off};
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_MISS_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && mem_rsp_valid) |=> (rsp_valid && !rsp_hit)); // R3
    AST_HIT_NEXT: assert property (@(posedge clk) disable iff (rst)
        (lk_use && lk_hit) |=> (rsp_valid && rsp_hit)); // R4
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0)); // R5
    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req); // R9
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        base_wr,
    input  logic [31:0] base_wdata,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [1:0]  rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    logic [VA_W-1:0] base_q;
    logic            lk_hit;
    xent_t           lk_ent;
    logic            lk_use;
    logic            fill_en;
    xent_t           fill_ent;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (base_wr) base_q <= base_wdata;
    end

    xlat_cam #(.N(ENTRIES)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .lk_use   (lk_use),
        .lk_hit   (lk_hit),
        .lk_ent   (lk_ent),
        .fill_en  (fill_en),
        .fill_ent (fill_ent),
        .flush    (base_wr)
    );

    xlat_walker u_walk (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .base          (base_q),
        .lk_hit        (lk_hit),
        .lk_ent        (lk_ent),
        .lk_use        (lk_use),
        .fill_en       (fill_en),
        .fill_ent      (fill_ent),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr)
    );

    AST_BUSY_WHILE_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready); // R9
endmodule

// File: tb/xlat_unit_bench.sv
module xlat_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        base_wr;
    logic [31:0] base_wdata;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #2 clk = ~clk;

    xlat_unit u_xlat_unit (.*);

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;
    int          reads_seen = 0;
    logic [31:0] last_addr  = '0;
    logic [31:0] base_cur   = '0;

    // Table contents: page v present unless v[7:6]==11, rights v[5:4], ppn v ^ base[31:12]
    function automatic logic [31:0] pte_at(logic [31:0] a);
        logic [31:0] idx;
        logic [19:0] v;
        idx = (a - base_cur) >> 2;
        v   = idx[19:0];
        return {(v[7:6] != 2'b11), v[5:4], 9'd0, v ^ base_cur[31:12]};
    endfunction

    function automatic logic [1:0] exp_fault(logic [19:0] v, logic [1:0] k);
        logic ok;
        if (v[7:6] == 2'b11) return 2'b01;
        case (k)
            2'b00:   ok = (v[5:4] == 2'b00) || (v[5:4] == 2'b01);
            2'b01:   ok = (v[5:4] == 2'b01);
            2'b10:   ok = (v[5:4] == 2'b10);
            default: ok = 1'b0;
        endcase
        return ok ? 2'b00 : 2'b10;
    endfunction

    function automatic logic [31:0] exp_paddr(logic [31:0] va, logic [1:0] k);
        if (exp_fault(va[31:12], k) != 2'b00) return 32'd0;
        return {va[31:12] ^ base_cur[31:12], va[11:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one word returned one cycle after each read request
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_rd_req) begin
                reads_seen++;
                last_addr = mem_rd_addr;
                @(negedge clk);
                mem_rsp_data  = pte_at(last_addr);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    logic [31:0] r_pa;
    logic        r_hit;
    logic [1:0]  r_flt;
    int          r_reads;
    int          r_wait;
    logic        r_ready1;

    task automatic run_req(input logic [31:0] va, input logic [1:0] k);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        reads_seen = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = k;
        @(negedge clk);
        req_valid = 1'b0;
        r_ready1  = req_ready;
        r_wait    = 0;
        while (!rsp_valid && r_wait < 100) begin
            @(negedge clk);
            r_wait++;
        end
        r_pa    = rsp_paddr;
        r_hit   = rsp_hit;
        r_flt   = rsp_fault;
        r_reads = reads_seen;
    endtask

    task automatic xact(input logic [31:0] va, input logic [1:0] k,
                        input bit exp_hit, input string req);
        run_req(va, k);
        check(rsp_valid, req, "response present", {31'd0, rsp_valid}, 32'd1);
        check(r_hit == exp_hit, req, "hit flag", {31'd0, r_hit}, {31'd0, exp_hit});
        check(r_flt == exp_fault(va[31:12], k), req, "fault code (R5/R6)",
              {30'd0, r_flt}, {30'd0, exp_fault(va[31:12], k)});
        check(r_pa == exp_paddr(va, k), req, "paddr (R2)", r_pa, exp_paddr(va, k));
        if (exp_hit) begin
            check(r_wait == 0, "R4", "hit latency", r_wait, 0);
            check(r_reads == 0, "R4", "reads on hit", r_reads, 0);
        end else begin
            check(r_reads == 1, "R3", "reads on miss", r_reads, 1);
            check(last_addr == base_cur + {10'd0, va[31:12], 2'b00}, "R3",
                  "entry address", last_addr, base_cur + {10'd0, va[31:12], 2'b00});
            check(r_ready1 == 1'b0, "R9", "ready during refill", {31'd0, r_ready1}, 0);
        end
    endtask

    task automatic write_base(input logic [31:0] b);
        @(negedge clk);
        base_wr    = 1'b1;
        base_wdata = b;
        base_cur   = b;
        @(negedge clk);
        base_wr    = 1'b0;
    endtask

    // {vaddr, kind, expected hit}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {32'h0001_0123, 2'd0, 1'b0},
        {32'h0001_0123, 2'd1, 1'b1},
        {32'h0001_0FFF, 2'd2, 1'b1},
        {32'h0000_0004, 2'd0, 1'b0},
        {32'h0000_0008, 2'd1, 1'b1},
        {32'h0002_0ABC, 2'd2, 1'b0},
        {32'h0002_0000, 2'd0, 1'b1},
        {32'h000C_0010, 2'd0, 1'b0},
        {32'h000C_0010, 2'd0, 1'b0},
        {32'h0003_0555, 2'd0, 1'b0},
        {32'h0003_0556, 2'd2, 1'b1},
        {32'h0001_0000, 2'd0, 1'b1}
    };

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        base_wr = 1'b0; base_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 1);
        check(rsp_valid == 1'b0, "R1", "no response after reset", {31'd0, rsp_valid}, 0);
        check(mem_rd_req == 1'b0, "R1", "no read after reset", {31'd0, mem_rd_req}, 0);

        write_base(32'h0010_0000);
        for (int i = 0; i < NV; i++)
            xact(VEC[i][34:3], VEC[i][2:1], VEC[i][0], "R6");

        // R9: no extra response after the last one
        repeat (3) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R9", "single response", {31'd0, rsp_valid}, 0);
        end

        // R8: new base flushes and is used for refill
        write_base(32'h0020_0000);
        xact(32'h0001_0040, 2'd0, 1'b0, "R8");
        write_base(32'h0020_0000);

        // R7: fill all 16 entries, then replacement order
        for (int i = 0; i < 16; i++)
            xact({20'h00100 + 20'(i), 12'h010}, 2'd0, 1'b0, "R7");
        xact(32'h0010_0020, 2'd0, 1'b1, "R7");
        xact(32'h0011_0000, 2'd0, 1'b0, "R7");
        xact(32'h0010_0030, 2'd0, 1'b1, "R7");
        xact(32'h0010_1000, 2'd0, 1'b0, "R7");
        xact(32'h0010_F000, 2'd0, 1'b1, "R7");
        xact(32'h0010_2000, 2'd0, 1'b0, "R7");

        // R1 style cold start after reset: previously cached page misses
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; base_cur = '0;
        write_base(32'h0020_0000);
        xact(32'h0010_F000, 2'd0, 1'b0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule